// File: doc/BRIEF.md
# Duplicated Framed Spectrum Sender

This block carries one frame of spectrum bins from a transform engine to a byte-wide host link. After a start pulse it pulls bins in groups. Each group makes one packet, laid out as follows:

- a four-byte opening marker;
- a one-byte packet number;
- the bins of the group, each as a real word and then an imaginary word, most significant byte first;
- a four-byte closing marker.

Each packet goes out twice, back to back, so the host can compare or choose between the two copies when a byte is corrupted or lost on the link.

The bins of the current group are held in a local store. The second copy is replayed from that store, and the transform output is never read twice. On the input side, bins are taken only while a group is being collected. On the output side, bytes move only when the downstream FIFO signals ready. A single-cycle done pulse marks the end of the frame.

Top module: `pkt_dup_tx`

## Requirements
- R1: After reset, `bin_ready_o`, `byte_valid_o` and `done_o` are all low, and they stay low until `start_i` is seen.
- R2: A `start_i` pulse while idle begins a frame, with `bin_ready_o` high from the next cycle. A `start_i` pulse while a frame is in progress has no effect.
- R3: Bytes 0 to 3 of every packet are A5, 5A, C3, 3C in that order.
- R4: Byte 4 of every packet is the packet number. Numbers count from 0 to NUM_BINS/BINS_PER_PKT-1 in frame order.
- R5: Bytes 5 to 5+4*BINS_PER_PKT-1 carry the bins in arrival order. Each bin is sent as real high byte, real low byte, imaginary high byte, imaginary low byte.
- R6: The last four bytes of every packet are 3C, C3, 5A, A5 in that order.
- R7: Every packet is sent twice in a row, and the second copy is identical to the first byte for byte.
- R8: While `byte_valid_o` is high and `byte_ready_i` is low, `byte_o` holds its value and `byte_valid_o` stays high. No byte is dropped or repeated.
- R9: `done_o` rises for exactly one cycle. It rises in the cycle after the last byte of the second copy of the last packet is accepted.
- R10: A frame carries exactly NUM_BINS/BINS_PER_PKT packets, and no byte follows the last one. `bin_ready_o` and `byte_valid_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a frame (ignored while busy) |
| bin_valid_i | input | 1 | Bin word offered |
| bin_re_i | input | BIN_W | Real part of bin |
| bin_im_i | input | BIN_W | Imaginary part of bin |
| bin_ready_o | output | 1 | Block takes a bin this cycle if valid |
| byte_o | output | 8 | Output byte |
| byte_valid_o | output | 1 | Output byte is valid |
| byte_ready_i | input | 1 | Downstream accepts the byte |
| done_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
Three frames are run, each with a different bin pattern:

- **Counting ramp** (real part rising, imaginary part its complement), with the output always ready. Any swap of byte order or of real and imaginary parts shows up at once.
- **Pseudo-random bin words**, with gaps on the input and random stalls on the output. This separates correct hold-under-stall behaviour from dropped or repeated bytes.
- **Alternating all-ones, all-zeros and 8001 words**, with a start pulse injected mid-frame. This shows whether a stray start restarts the frame or alters the packet count and numbering.

Every accepted byte is compared against a queue built from the requirements. The queue tags header, number, payload, duplicate and tail positions separately.

// File: rtl/pkt_dup_tx_pkg.sv
package pkt_dup_tx_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_FILL = 2'd1,
      ST_SEND = 2'd2
   } tx_state_e;

   localparam int          MARK_LEN  = 4;
   localparam logic [31:0] OPEN_MARK = 32'hA55A_C33C;
   localparam logic [31:0] CLOSE_MARK = 32'h3CC3_5AA5;

   function automatic logic [7:0] mark_byte(input logic [31:0] mark, input int idx);
      logic [31:0] sh;
      sh = mark >> (8 * (MARK_LEN - 1 - idx));
      return sh[7:0];
   endfunction

endpackage

// File: rtl/pkt_bin_store.sv
module pkt_bin_store #(
   parameter int DEPTH  = 64,
   parameter int WORD_W = 32,
   parameter int AW     = 6
) (
   input  logic              clk,
   input  logic              wr_en_i,
   input  logic [AW-1:0]     wr_addr_i,
   input  logic [WORD_W-1:0] wr_data_i,
   input  logic [AW-1:0]     rd_addr_i,
   output logic [WORD_W-1:0] rd_data_o
);

   logic [DEPTH*WORD_W-1:0] flat;

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
      logic [WORD_W-1:0] q;
      always_ff @(posedge clk) begin
         if (wr_en_i && (int'(wr_addr_i) == gi)) q <= wr_data_i;
      end
      assign flat[gi*WORD_W +: WORD_W] = q;
   end

   assign rd_data_o = flat[int'(rd_addr_i)*WORD_W +: WORD_W];

endmodule

// File: rtl/pkt_seq_ctrl.sv
module pkt_seq_ctrl
   import pkt_dup_tx_pkg::*;
#(
   parameter int NUM_PKTS     = 16,
   parameter int BINS_PER_PKT = 64,
   parameter int PKT_BYTES    = 265,
   parameter int AW           = 6,
   parameter int PW           = 9,
   parameter int KW           = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          bin_valid_i,
   input  logic          byte_ready_i,
   output logic          bin_ready_o,
   output logic          wr_en_o,
   output logic [AW-1:0] wr_addr_o,
   output logic          byte_valid_o,
   output logic [PW-1:0] pos_o,
   output logic [KW-1:0] pkt_idx_o,
   output logic          done_o
);

   localparam logic [AW-1:0] FILL_LAST = AW'(BINS_PER_PKT - 1);
   localparam logic [PW-1:0] POS_LAST  = PW'(PKT_BYTES - 1);
   localparam logic [KW-1:0] PKT_LAST  = KW'(NUM_PKTS - 1);

   tx_state_e     state;
   logic [AW-1:0] fill_cnt;
   logic [PW-1:0] pos;
   logic [KW-1:0] pkt;
   logic          copy;
   logic          done_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         fill_cnt <= '0;
         pos      <= '0;
         pkt      <= '0;
         copy     <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state)
            ST_IDLE: if (start_i) begin
               state    <= ST_FILL;
               fill_cnt <= '0;
               pkt      <= '0;
            end
            ST_FILL: if (bin_valid_i) begin
               fill_cnt <= fill_cnt + 1'b1;
               if (fill_cnt == FILL_LAST) begin
                  state <= ST_SEND;
                  pos   <= '0;
                  copy  <= 1'b0;
               end
            end
            ST_SEND: if (byte_ready_i) begin
               if (pos == POS_LAST) begin
                  pos <= '0;
                  if (!copy) begin
                     copy <= 1'b1;
                  end else if (pkt == PKT_LAST) begin
                     state  <= ST_IDLE;
                     done_q <= 1'b1;
                  end else begin
                     pkt      <= pkt + 1'b1;
                     state    <= ST_FILL;
                     fill_cnt <= '0;
                  end
               end else begin
                  pos <= pos + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign bin_ready_o  = (state == ST_FILL);
   assign wr_en_o      = bin_ready_o && bin_valid_i;
   assign wr_addr_o    = fill_cnt;
   assign byte_valid_o = (state == ST_SEND);
   assign pos_o        = pos;
   assign pkt_idx_o    = pkt;
   assign done_o       = done_q;

   AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid_o && !byte_ready_i |=> byte_valid_o && $stable(pos_o) && $stable(pkt_idx_o)); // R8
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R9
   AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> $past(byte_valid_o && byte_ready_i)); // R9
   AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(bin_ready_o && byte_valid_o)); // R10

endmodule

// File: rtl/pkt_byte_mux.sv
module pkt_byte_mux
   import pkt_dup_tx_pkg::*;
#(
   parameter int BINS_PER_PKT = 64,
   parameter int BIN_W        = 16,
   parameter int AW           = 6,
   parameter int PW           = 9,
   parameter int KW           = 4
) (
   input  logic [PW-1:0]      pos_i,
   input  logic [KW-1:0]      pkt_idx_i,
   input  logic [2*BIN_W-1:0] rd_data_i,
   output logic [AW-1:0]      rd_addr_o,
   output logic [7:0]         byte_o
);

   localparam int BPB        = 2 * BIN_W / 8;
   localparam int PAY_START  = MARK_LEN + 1;
   localparam int TAIL_START = PAY_START + BPB * BINS_PER_PKT;

   int                 p;
   int                 off;
   logic [2*BIN_W-1:0] sh;

   always_comb begin
      p         = int'(pos_i);
      off       = 0;
      sh        = '0;
      rd_addr_o = '0;
      if (p < MARK_LEN) begin
         byte_o = mark_byte(OPEN_MARK, p);
      end else if (p == MARK_LEN) begin
         byte_o = 8'(pkt_idx_i);
      end else if (p < TAIL_START) begin
         off       = p - PAY_START;
         rd_addr_o = AW'(off / BPB);
         sh        = rd_data_i >> (8 * (BPB - 1 - (off % BPB)));
         byte_o    = sh[7:0];
      end else begin
         byte_o = mark_byte(CLOSE_MARK, p - TAIL_START);
      end
   end

endmodule

// File: rtl/pkt_dup_tx.sv
module pkt_dup_tx #(
   parameter int NUM_BINS     = 1024,
   parameter int BINS_PER_PKT = 64,
   parameter int BIN_W        = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             bin_valid_i,
   input  logic [BIN_W-1:0] bin_re_i,
   input  logic [BIN_W-1:0] bin_im_i,
   output logic             bin_ready_o,
   output logic [7:0]       byte_o,
   output logic             byte_valid_o,
   input  logic             byte_ready_i,
   output logic             done_o
);

   localparam int NUM_PKTS  = NUM_BINS / BINS_PER_PKT;
   localparam int PKT_BYTES = 2 * pkt_dup_tx_pkg::MARK_LEN + 1 + (2 * BIN_W / 8) * BINS_PER_PKT;
   localparam int AW        = $clog2(BINS_PER_PKT);
   localparam int PW        = $clog2(PKT_BYTES);
   localparam int KW        = (NUM_PKTS > 1) ? $clog2(NUM_PKTS) : 1;

   if (NUM_BINS % BINS_PER_PKT != 0) begin : g_bad_split
      $error("NUM_BINS must be a multiple of BINS_PER_PKT");
   end
   if (BIN_W % 8 != 0 || BIN_W < 8) begin : g_bad_width
      $error("BIN_W must be a whole number of bytes");
   end
   if (NUM_PKTS > 256 || NUM_PKTS < 1) begin : g_bad_count
      $error("packet number must fit one byte");
   end
   if (BINS_PER_PKT < 2) begin : g_bad_group
      $error("BINS_PER_PKT must be at least 2");
   end

   logic              wr_en;
   logic [AW-1:0]     wr_addr;
   logic [AW-1:0]     rd_addr;
   logic [2*BIN_W-1:0] rd_data;
   logic [PW-1:0]     pos;
   logic [KW-1:0]     pkt_idx;

   pkt_seq_ctrl #(
      .NUM_PKTS(NUM_PKTS), .BINS_PER_PKT(BINS_PER_PKT), .PKT_BYTES(PKT_BYTES),
      .AW(AW), .PW(PW), .KW(KW)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .bin_valid_i(bin_valid_i),
      .byte_ready_i(byte_ready_i), .bin_ready_o(bin_ready_o), .wr_en_o(wr_en),
      .wr_addr_o(wr_addr), .byte_valid_o(byte_valid_o), .pos_o(pos),
      .pkt_idx_o(pkt_idx), .done_o(done_o)
   );

   pkt_bin_store #(.DEPTH(BINS_PER_PKT), .WORD_W(2*BIN_W), .AW(AW)) u_store (
      .clk(clk), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i({bin_re_i, bin_im_i}),
      .rd_addr_i(rd_addr), .rd_data_o(rd_data)
   );

   pkt_byte_mux #(.BINS_PER_PKT(BINS_PER_PKT), .BIN_W(BIN_W), .AW(AW), .PW(PW), .KW(KW)) u_mux (
      .pos_i(pos), .pkt_idx_i(pkt_idx), .rd_data_i(rd_data), .rd_addr_o(rd_addr), .byte_o(byte_o)
   );

   AST_OPEN_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid_o && (pos == '0) |-> byte_o == 8'hA5); // R3
   AST_STALL_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      byte_valid_o && !byte_ready_i |=> $stable(byte_o)); // R8
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bin_ready_o) |-> $past(start_i) || $past(byte_valid_o)); // R2

endmodule

// File: tb/pkt_dup_tx_tb.sv
module pkt_dup_tx_tb;

   localparam int NB  = 1024;
   localparam int BPP = 64;
   localparam int BW  = 16;
   localparam int NP  = NB / BPP;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic          bin_valid_i = 1'b0;
   logic [BW-1:0] bin_re_i = '0;
   logic [BW-1:0] bin_im_i = '0;
   logic          bin_ready_o;
   logic [7:0]    byte_o;
   logic          byte_valid_o;
   logic          byte_ready_i = 1'b1;
   logic          done_o;

   pkt_dup_tx #(.NUM_BINS(NB), .BINS_PER_PKT(BPP), .BIN_W(BW)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .bin_valid_i(bin_valid_i),
      .bin_re_i(bin_re_i), .bin_im_i(bin_im_i), .bin_ready_o(bin_ready_o),
      .byte_o(byte_o), .byte_valid_o(byte_valid_o), .byte_ready_i(byte_ready_i),
      .done_o(done_o)
   );

   always #5 clk = ~clk;

   int            n_chk = 0;
   int            n_bad = 0;
   logic [7:0]    exp_q[$];
   string         tag_q[$];
   logic [BW-1:0] re_a[NB];
   logic [BW-1:0] im_a[NB];
   bit            ready_rand = 1'b0;
   logic [15:0]   rlfsr = 16'hACE1;
   bit            expect_done = 1'b0;
   bit            after_done = 1'b0;
   int            frames_done = 0;
   bit            prev_stall = 1'b0;
   logic [7:0]    prev_byte = '0;
   bit            finished = 1'b0;

   task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic push(input logic [7:0] b, input string tag);
      exp_q.push_back(b);
      tag_q.push_back(tag);
   endtask

   task automatic build_expected();
      for (int p = 0; p < NP; p++) begin
         for (int c = 0; c < 2; c++) begin
            push(8'hA5, "R3"); push(8'h5A, "R3"); push(8'hC3, "R3"); push(8'h3C, "R3");
            push(8'(p), "R4");
            for (int b = 0; b < BPP; b++) begin
               push(re_a[p*BPP+b][15:8], c == 0 ? "R5" : "R7");
               push(re_a[p*BPP+b][7:0],  c == 0 ? "R5" : "R7");
               push(im_a[p*BPP+b][15:8], c == 0 ? "R5" : "R7");
               push(im_a[p*BPP+b][7:0],  c == 0 ? "R5" : "R7");
            end
            push(8'h3C, "R6"); push(8'hC3, "R6"); push(8'h5A, "R6"); push(8'hA5, "R6");
         end
      end
   endtask

   task automatic run_frame(input bit gaps);
      int target;
      target = frames_done + 1;
      build_expected();
      @(posedge clk); #1;
      check(bin_ready_o == 1'b0 && byte_valid_o == 1'b0, "R2", "idle before start", int'(bin_ready_o), 0);
      start_i = 1'b1;
      @(posedge clk); #1;
      start_i = 1'b0;
      check(bin_ready_o == 1'b1, "R2", "ready after start", int'(bin_ready_o), 1);
      for (int i = 0; i < NB; i++) begin
         bin_valid_i = 1'b1;
         bin_re_i    = re_a[i];
         bin_im_i    = im_a[i];
         do @(negedge clk); while (!bin_ready_o);
         @(posedge clk); #1;
         bin_valid_i = 1'b0;
         if (gaps && (i % 5 == 0)) begin
            @(posedge clk); #1;
         end
      end
      wait (frames_done == target);
      repeat (20) @(negedge clk);
      check(byte_valid_o == 1'b0 && bin_ready_o == 1'b0, "R10", "quiet after frame", int'(byte_valid_o), 0);
      check(exp_q.size() == 0, "R10", "bytes left over", exp_q.size(), 0);
   endtask

   always @(posedge clk) begin
      #1;
      rlfsr = {rlfsr[14:0], rlfsr[15] ^ rlfsr[13] ^ rlfsr[12] ^ rlfsr[10]};
      byte_ready_i = ready_rand ? rlfsr[0] : 1'b1;
   end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (prev_stall)
            check(byte_valid_o && byte_o == prev_byte, "R8", "held under stall", int'(byte_o), int'(prev_byte));
         prev_stall = byte_valid_o && !byte_ready_i;
         prev_byte  = byte_o;
         if (byte_valid_o && bin_ready_o)
            check(1'b0, "R10", "both ready and valid", 1, 0);
         if (expect_done) begin
            check(done_o == 1'b1, "R9", "done pulse", int'(done_o), 1);
            expect_done = 1'b0;
            after_done  = 1'b1;
            frames_done++;
         end else if (after_done) begin
            check(done_o == 1'b0, "R9", "done one cycle", int'(done_o), 0);
            after_done = 1'b0;
         end else if (done_o) begin
            check(1'b0, "R9", "unexpected done", 1, 0);
         end
         if (byte_valid_o && byte_ready_i) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R10", "extra byte", int'(byte_o), 0);
            end else begin
               logic [7:0] e;
               string      t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(byte_o == e, t, "stream byte", int'(byte_o), int'(e));
               if (exp_q.size() == 0) expect_done = 1'b1;
            end
         end
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(posedge clk);
      #1;
      // R1: reset values while held in reset and just after release
      check(bin_ready_o == 1'b0 && byte_valid_o == 1'b0 && done_o == 1'b0, "R1", "reset outputs",
            int'({bin_ready_o, byte_valid_o, done_o}), 0);
      rst_n = 1'b1;
      repeat (4) @(posedge clk);
      #1;
      check(bin_ready_o == 1'b0 && byte_valid_o == 1'b0 && done_o == 1'b0, "R1", "idle without start",
            int'({bin_ready_o, byte_valid_o, done_o}), 0);

      // frame 1: ramp, output always ready
      for (int i = 0; i < NB; i++) begin
         re_a[i] = BW'(i * 3 + 16'h0102);
         im_a[i] = ~BW'(i);
      end
      ready_rand = 1'b0;
      run_frame(1'b0);

      // frame 2: pseudo-random words, input gaps, output stalls
      d = 32'h1234_5678;
      for (int i = 0; i < NB; i++) begin
         d = d * 32'd1664525 + 32'd1013904223;
         re_a[i] = d[31:16];
         im_a[i] = d[15:0];
      end
      ready_rand = 1'b1;
      run_frame(1'b1);

      // frame 3: extreme words, stray start mid-frame must be ignored (R2)
      for (int i = 0; i < NB; i++) begin
         re_a[i] = (i % 3 == 0) ? 16'hFFFF : ((i % 3 == 1) ? 16'h0000 : 16'h8001);
         im_a[i] = (i % 2 == 0) ? 16'h0000 : 16'hFFFF;
      end
      fork
         begin
            repeat (600) @(posedge clk);
            #1 start_i = 1'b1;
            @(posedge clk);
            #1 start_i = 1'b0;
         end
      join_none
      run_frame(1'b0);
      check(frames_done == 3, "R2", "frame count after stray start", frames_done, 3);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule